// File: doc/BRIEF.md
# Chainable SPI Command Register Slave

This block is a serial peripheral slave for a four-wire SPI link that serves a small bank of 8-bit read/write registers. A master sends 16-bit command frames on the serial input. In the same transfer the slave sends back a 16-bit response on the serial output. All serial pins are sampled by a system clock that runs at least four times faster than the serial clock, and all edge detection happens in that clock domain.

While chip select is held low, the slave acts as a plain shift register. Bits that enter on the serial input leave on the serial output 16 clocks later. Several devices can therefore share one chip select line in a chain.

A command is applied only when chip select is released. Two conditions must hold:
- the number of serial clocks seen is a nonzero multiple of eight, and
- chip select never changed while the serial clock was high.

If either condition fails, the frame is dropped and an error flag is raised. The flag is reported once, in the next response. Each response echoes the address of the last accepted command together with the current content of that register. A read therefore returns its data in the frame that follows it.

Top module: `spi_chain_regslave`

## Requirements
- R1: While chip select is high, `sdo_oe` is 0. Once chip select goes low, `sdo_oe` becomes 1 and `sdo` carries bit 15 of the pending response word.
- R2: The serial input is sampled on falling serial clock edges and the serial output changes on rising edges. Both directions are most significant bit first.
- R3: A command word has bit 15 = 1 for write and 0 for read, bits 14..8 as the register address and bits 7..0 as the write data. A write to address k (k < NUM_REGS) sets register k. Registers change only after chip select rises and never during shifting. All registers reset to 0 and appear on `regs_o`, register k at bits 8k+7..8k.
- R4: The response word is laid out as follows: bit 15 is the error flag, bits 14..8 are the address of the last accepted command, and bits 7..0 are the current content of that register. After reset the response is 0x0000.
- R5: With more than 16 clocks in one select period, each bit received on `sdi` reappears on `sdo` 16 clocks later. The command applied is the last 16 bits received.
- R6: A frame whose clock count is a nonzero multiple of 8 (16, 24, 32 …) is accepted. A frame whose clock count is not a multiple of 8 is discarded and sets the error flag.
- R7: A set error flag appears in bit 15 of the next response and is cleared once that response is loaded for output.
- R8: If chip select changes while the serial clock is high, the frame is discarded and the error flag is set.
- R9: A write to an address at or above NUM_REGS changes no register. The response data byte for such an address is 0.
- R10: A select period with no serial clocks changes nothing and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo`; the pad is high impedance when 0 |
| regs_o | output | NUM_REGS*8 | Register bank contents, register k at bits 8k+7..8k |

## Verification
The bench builds the block with its defaults: four registers, a two-stage synchronizer and a count granularity of 8. With only four registers, addresses 4 through 127 are undefined, so writes to and reads from unmapped addresses can be exercised directly. The serial clock half period is six system clocks, which leaves margin for the synchronizer and output-register latency when the bench samples near the end of each high phase. These defaults also cover 24- and 32-clock chained frames, a 12-clock frame that must be rejected, and a select release with the clock still high.

// File: rtl/spi_chain_pkg.sv
`timescale 1ns/1ps
package spi_chain_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/spi_chain_sync.sv
`timescale 1ns/1ps
module spi_chain_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic sclk_lvl_o,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic cs_act_o,
    output logic sdi_o
);
    localparam int PW = STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] sclk;
        logic [PW-1:0] cs;
        logic [PW-1:0] sdi;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.sclk = {sync_q.sclk[PW-2:0], sclk_i};
        sync_d.cs   = {sync_q.cs[PW-2:0], cs_n_i};
        sync_d.sdi  = {sync_q.sdi[PW-2:0], sdi_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sclk <= '0;
            sync_q.cs   <= '1;
            sync_q.sdi  <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // Bit STAGES-1 is the synchronized level, bit STAGES the previous one.
    assign sclk_lvl_o  = sync_q.sclk[STAGES-1];
    assign sclk_rise_o =  sync_q.sclk[STAGES-1] && !sync_q.sclk[STAGES];
    assign sclk_fall_o = !sync_q.sclk[STAGES-1] &&  sync_q.sclk[STAGES];
    assign cs_fall_o   = !sync_q.cs[STAGES-1]   &&  sync_q.cs[STAGES];
    assign cs_rise_o   =  sync_q.cs[STAGES-1]   && !sync_q.cs[STAGES];
    assign cs_act_o    = !sync_q.cs[STAGES];
    assign sdi_o       = sync_q.sdi[STAGES-1];
endmodule

// File: rtl/spi_chain_shifter.sv
`timescale 1ns/1ps
module spi_chain_shifter
    import spi_chain_pkg::*;
#(
    parameter int GRAN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise_i,
    input  logic               sclk_fall_i,
    input  logic               sclk_lvl_i,
    input  logic               cs_fall_i,
    input  logic               cs_rise_i,
    input  logic               cs_act_i,
    input  logic               sdi_i,
    input  logic [FRAME_W-1:0] tx_i,
    output logic               sdo_o,
    output logic [FRAME_W-1:0] cmd_o,
    output logic               ok_o,
    output logic               bad_o
);
    localparam int CNT_W = (GRAN > 1) ? $clog2(GRAN) : 1;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               any;
        logic               proto;
        logic               sdo;
        logic               ok;
        logic               bad;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d     = shf_q;
        shf_d.ok  = 1'b0;
        shf_d.bad = 1'b0;
        if (cs_fall_i) begin
            shf_d.sr    = tx_i;
            shf_d.cnt   = '0;
            shf_d.any   = 1'b0;
            shf_d.proto = sclk_lvl_i;
            shf_d.sdo   = tx_i[FRAME_W-1];
        end else if (cs_rise_i) begin
            if (shf_q.proto || sclk_lvl_i) begin
                shf_d.bad = 1'b1;
            end else if (shf_q.any) begin
                if (shf_q.cnt == '0) shf_d.ok  = 1'b1;
                else                 shf_d.bad = 1'b1;
            end
        end else if (cs_act_i) begin
            if (sclk_fall_i) begin
                shf_d.sr  = {shf_q.sr[FRAME_W-2:0], sdi_i};
                shf_d.cnt = shf_q.cnt + CNT_W'(1);
                shf_d.any = 1'b1;
            end
            if (sclk_rise_i) begin
                shf_d.sdo = shf_q.sr[FRAME_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign sdo_o = shf_q.sdo;
    assign cmd_o = shf_q.sr;
    assign ok_o  = shf_q.ok;
    assign bad_o = shf_q.bad;

    // R6
    frame_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (shf_q.cnt == '0 && $past(cs_rise_i)));

    // R1
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall_i |=> (sdo_o == $past(tx_i[FRAME_W-1])));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act_i && !cs_fall_i) |=> $stable(shf_q.sr));
endmodule

// File: rtl/spi_chain_regbank.sv
`timescale 1ns/1ps
module spi_chain_regbank
    import spi_chain_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  cmd_t                         cmd_i,
    input  logic                         ok_i,
    input  logic                         bad_i,
    input  logic                         load_i,
    output logic [FRAME_W-1:0]           tx_o,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [ADDR_W-1:0]               last;
        logic                            err;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_REGS-1:0] hit;
    logic [DATA_W-1:0]   rd_data;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign hit[g] = (cmd_i.addr == ADDR_W'(g));
    end

    always_comb begin
        bank_d  = bank_q;
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (bank_q.last == ADDR_W'(i)) rd_data = bank_q.regs[i];
        end
        if (load_i) bank_d.err = 1'b0;
        if (bad_i)  bank_d.err = 1'b1;
        if (ok_i) begin
            bank_d.last = cmd_i.addr;
            if (cmd_i.wr) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (hit[i]) bank_d.regs[i] = cmd_i.data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign tx_o   = {bank_q.err, bank_q.last, rd_data};
    assign regs_o = bank_q.regs;

    // R3
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_i |=> $stable(bank_q.regs));

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !bad_i) |=> !bank_q.err);

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_i |=> bank_q.err);

    // R9
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.last >= ADDR_W'(NUM_REGS)) |-> (tx_o[DATA_W-1:0] == '0));
endmodule

// File: rtl/spi_chain_regslave.sv
`timescale 1ns/1ps
module spi_chain_regslave
    import spi_chain_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int GRAN        = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       cs_n,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    logic sclk_rise, sclk_fall, sclk_lvl, cs_fall, cs_rise, cs_act, sdi_s;
    logic ok, bad;
    logic [FRAME_W-1:0] tx_word, cmd_word;
    cmd_t cmd;

    spi_chain_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .cs_n_i      (cs_n),
        .sdi_i       (sdi),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .sclk_lvl_o  (sclk_lvl),
        .cs_fall_o   (cs_fall),
        .cs_rise_o   (cs_rise),
        .cs_act_o    (cs_act),
        .sdi_o       (sdi_s)
    );

    spi_chain_shifter #(.GRAN(GRAN)) i_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .sclk_lvl_i  (sclk_lvl),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .cs_act_i    (cs_act),
        .sdi_i       (sdi_s),
        .tx_i        (tx_word),
        .sdo_o       (sdo),
        .cmd_o       (cmd_word),
        .ok_o        (ok),
        .bad_o       (bad)
    );

    assign cmd = cmd_t'(cmd_word);

    spi_chain_regbank #(.NUM_REGS(NUM_REGS)) i_regbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd),
        .ok_i   (ok),
        .bad_i  (bad),
        .load_i (cs_fall),
        .tx_o   (tx_word),
        .regs_o (regs_o)
    );

    assign sdo_oe = cs_act;

    // R1
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);
endmodule

// File: tb/test_spi_chain_regslave.sv
`timescale 1ns/1ps
module test_spi_chain_regslave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6 * CLK_PERIOD;
    localparam int NREG       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [NREG*8-1:0] regs_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [7:0] m_regs [NREG];
    logic [6:0] m_last = '0;
    logic       m_err  = 1'b0;
    logic [15:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_chain_regslave i_spi_chain_regslave (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (sclk),
        .cs_n   (cs_n),
        .sdi    (sdi),
        .sdo    (sdo),
        .sdo_oe (sdo_oe),
        .regs_o (regs_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_resp();
        logic [7:0] d;
        d = (m_last < NREG) ? m_regs[m_last] : 8'h00;
        return {m_err, m_last, d};
    endfunction

    function automatic logic [NREG*8-1:0] model_bank();
        logic [NREG*8-1:0] v;
        for (int k = 0; k < NREG; k++) v[k*8 +: 8] = m_regs[k];
        return v;
    endfunction

    // One select period of n clocks; hi_end leaves sclk high across the cs release.
    task automatic run_frame(input int n, input logic [63:0] mo, input bit hi_end,
                             input string tag, output logic [15:0] resp);
        logic [15:0] exp_resp;
        logic [63:0] got_all, exp_all;
        logic [NREG*8-1:0] snap;
        int nr;
        exp_resp = model_resp();
        m_err = 1'b0;
        snap = regs_o;
        got_all = '0;
        exp_all = '0;
        cs_n = 1'b0;
        #(HALF);
        check(sdo_oe == 1'b1, "R1 output enable while selected", {63'd0, sdo_oe}, 64'd1);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            sdi = mo[n-1-i];
            #(HALF);
            got_all[n-1-i] = sdo;
            exp_all[n-1-i] = (i < 16) ? exp_resp[15-i] : mo[n-1-(i-16)];
            if (i < n-1 || !hi_end) begin
                sclk = 1'b0;
                #(HALF);
            end
        end
        check(regs_o == snap, "R3 no register change during shifting", {32'd0, regs_o}, {32'd0, snap});
        cs_n = 1'b1;
        #(HALF);
        if (hi_end) begin
            sclk = 1'b0;
            #(HALF);
        end
        #(HALF);
        check(sdo_oe == 1'b0, "R1 output enable off after release", {63'd0, sdo_oe}, 64'd0);
        nr = (n < 16) ? n : 16;
        resp = '0;
        for (int i = 0; i < nr; i++) resp[15-i] = got_all[n-1-i];
        if (nr > 0)
            check(resp[15 -: 16] >> (16-nr) == exp_resp >> (16-nr),
                  {tag, " R2 response bits"}, {48'd0, resp}, {48'd0, exp_resp});
        if (n > 16)
            check(got_all == exp_all, "R5 chained bits delayed by 16", got_all, exp_all);
        if (n != 0) begin
            if ((n % 8) != 0 || hi_end) begin
                m_err = 1'b1;
            end else begin
                m_last = mo[14:8];
                if (mo[15] && mo[14:8] < NREG) m_regs[mo[14:8]] = mo[7:0];
            end
        end
        check(regs_o == model_bank(), {tag, " R3 register bank after frame"}, {32'd0, regs_o}, {32'd0, model_bank()});
    endtask

    task automatic t_reset();
        check(sdo_oe == 1'b0, "R1 reset output enable", {63'd0, sdo_oe}, 64'd0);
        check(regs_o == '0, "R3 reset register values", {32'd0, regs_o}, 64'd0);
    endtask

    task automatic t_write_read();
        run_frame(16, 64'h815A, 1'b0, "R3 write", got);
        check(got == 16'h0000, "R4 reset response", {48'd0, got}, 64'h0000);
        run_frame(16, 64'h0100, 1'b0, "R4 read", got);
        check(got == 16'h015A, "R4 echo after write", {48'd0, got}, 64'h015A);
        run_frame(16, 64'h0200, 1'b0, "R4 read", got);
        check(got == 16'h015A, "R4 read data in next frame", {48'd0, got}, 64'h015A);
        run_frame(16, 64'h83C3, 1'b0, "R3 write", got);
        check(got == 16'h0200, "R4 read of reset register", {48'd0, got}, 64'h0200);
        run_frame(16, 64'h0300, 1'b0, "R4 read", got);
        check(got == 16'h03C3, "R4 write then echo", {48'd0, got}, 64'h03C3);
    endtask

    task automatic t_daisy();
        run_frame(32, {32'd0, 16'hABCD, 16'h8277}, 1'b0, "R5 chain", got);
        check(got == 16'h03C3, "R5 first response in chain", {48'd0, got}, 64'h03C3);
        run_frame(16, 64'h0200, 1'b0, "R5 read", got);
        check(got == 16'h0277, "R5 last 16 bits applied", {48'd0, got}, 64'h0277);
    endtask

    task automatic t_mod8();
        run_frame(24, {40'd0, 8'h5E, 16'h8011}, 1'b0, "R6 24-bit", got);
        run_frame(16, 64'h0000, 1'b0, "R6 read", got);
        check(got == 16'h0011, "R6 24-clock frame accepted", {48'd0, got}, 64'h0011);
        run_frame(12, 64'h0822, 1'b0, "R6 12-bit", got);
        run_frame(16, 64'h0000, 1'b0, "R7 read", got);
        check(got == 16'h8011, "R7 error flag reported", {48'd0, got}, 64'h8011);
        run_frame(16, 64'h0000, 1'b0, "R7 read", got);
        check(got == 16'h0011, "R7 error flag cleared", {48'd0, got}, 64'h0011);
    endtask

    task automatic t_proto();
        run_frame(16, 64'h8155, 1'b1, "R8 clock high", got);
        check(regs_o[15:8] == 8'h5A, "R8 frame discarded", {56'd0, regs_o[15:8]}, 64'h5A);
        run_frame(16, 64'h0100, 1'b0, "R8 read", got);
        check(got == 16'h8011, "R8 error flag set", {48'd0, got}, 64'h8011);
        run_frame(16, 64'h0100, 1'b0, "R8 read", got);
        check(got == 16'h015A, "R8 register kept", {48'd0, got}, 64'h015A);
    endtask

    task automatic t_undef();
        run_frame(16, 64'hC0AA, 1'b0, "R9 write undefined", got);
        run_frame(16, 64'h4000, 1'b0, "R9 read", got);
        check(got == 16'h4000, "R9 undefined address data zero", {48'd0, got}, 64'h4000);
        check(regs_o == model_bank(), "R9 no register changed", {32'd0, regs_o}, {32'd0, model_bank()});
    endtask

    task automatic t_zero();
        run_frame(0, 64'h0, 1'b0, "R10 empty", got);
        run_frame(16, 64'h0100, 1'b0, "R10 read", got);
        check(got == 16'h4000, "R10 empty frame no effect", {48'd0, got}, 64'h4000);
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) m_regs[k] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        t_write_read();
        t_daisy();
        t_mod8();
        t_proto();
        t_undef();
        t_zero();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule